// File: doc/BRIEF.md
# Short-I/O Slave Window Decoder

This block sits between a 16-bit short I/O backplane and the registers of a graphics board. It claims a 64-byte window whose base is set by three 4-bit switch inputs. For each bus cycle it checks the address modifier code, sorts the transfer by size, and then drives one device select: controller status, controller address register, controller data registers, or the board's byte-wide status register. A legal access receives a data-transfer acknowledge a fixed number of clocks after its select. An illegal transfer size receives a bus error instead.

All bus inputs pass through a two-flop synchroniser into the local clock before any decoding. The three switch inputs and the privilege-ignore input are static configuration and are used directly. The top switch gives A15..A12 and the middle switch gives A11..A8. The low switch has two jobs: its bits [1:0] give A7..A6, and its bits [3:2] give the AM2 and AM1 values the decoder must see. A cycle is active while either data strobe is low. The outputs are active high.

Top module: `sio_slave_decoder`

## Requirements
- R1: A cycle can be claimed only when address bits 15..12 equal `cfg_base_hi`, bits 11..8 equal `cfg_base_mid` and bits 7..6 equal `cfg_base_lo[1:0]`. Any other address gets no select, no acknowledge and no bus error.
- R2: AM bits 5, 4, 3 and 0 must read 1, 0, 1 and 1. Any other value on these bits leaves the cycle unanswered.
- R3: AM bit 2 must equal `cfg_base_lo[3]` and AM bit 1 must equal `cfg_base_lo[2]`. So switch value 0 answers code 0x29, 8 answers 0x2D and 4 answers 0x2B.
- R4: When `cfg_am2_any` is 1, AM bit 2 is not compared, and the window answers both 0x29 and 0x2D.
- R5: At word index 0 (address bits 5..1 = 0), a read (`write_n`=1) asserts `sel_ctl_status` and a write asserts `sel_ctl_addr`.
- R6: Word index 1 asserts `sel_ctl_data`. Word index 2 asserts `sel_hw_status`, which covers byte offset 5. At most one select is high at any time.
- R7: Transfer size is decoded from the strobes. Both strobes low is a word, `ds0_n` low alone is an odd byte, and `ds1_n` low alone is an even byte. A cycle with `lword_n` low, or an even-byte cycle, that hits the window raises `berr` three clocks after the strobe falls, with no select and no `dtack`.
- R8: A legal cycle to a mapped word raises its select on the third clock edge after the strobe falls. `dtack` follows `ACK_DELAY` clocks later, and while `dtack` is high exactly one select is high.
- R9: The select, `dtack` and `berr` stay high while a strobe stays low. They all clear on the third clock edge after both strobes go high.
- R10: A legal-size cycle inside the window at word index 3 or above gets no response at all.
- R11: After reset, all selects, `dtack` and `berr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 15 | Address bits 15..1 |
| bus_am | input | 6 | Address modifier code |
| ds0_n | input | 1 | Odd-byte data strobe, active low |
| ds1_n | input | 1 | Even-byte data strobe, active low |
| lword_n | input | 1 | Longword qualifier, active low |
| write_n | input | 1 | Direction, 0 for write |
| cfg_base_hi | input | 4 | Base bits 15..12 |
| cfg_base_mid | input | 4 | Base bits 11..8 |
| cfg_base_lo | input | 4 | [1:0] base bits 7..6, [3:2] expected AM2/AM1 |
| cfg_am2_any | input | 1 | 1 makes AM2 don't-care |
| sel_ctl_status | output | 1 | Controller status read select |
| sel_ctl_addr | output | 1 | Controller address register write select |
| sel_ctl_data | output | 1 | Controller data register select |
| sel_hw_status | output | 1 | Board status byte select |
| dtack | output | 1 | Data transfer acknowledge |
| berr | output | 1 | Bus error |

## Verification
A stuck or wrongly advanced cycle state appears at the ports within one cycle-plus-release period. Either the select would be missing or misrouted on the third edge after the strobe, or `dtack` would arrive one edge early or late, or a response would outlive the strobe release by more than three edges. A decoding error in the window or modifier compare shows as a response where none is due, or as silence where one is due. Each case is caught on the first affected cycle, because every response is sampled at the exact edge it must change.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int ADDR_HI  = 15;
    localparam int IDX_W    = 5;   // word index inside the 64-byte window
    localparam int AM_W     = 6;

    localparam logic [IDX_W-1:0] IDX_CTL_REG  = 5'd0;
    localparam logic [IDX_W-1:0] IDX_CTL_DATA = 5'd1;
    localparam logic [IDX_W-1:0] IDX_HW_STAT  = 5'd2;

    typedef enum logic [1:0] {
        SZ_WORD,
        SZ_ODD,
        SZ_EVEN,
        SZ_LONG
    } xfer_size_e;

    typedef enum logic [2:0] {
        DEV_NONE,
        DEV_CTL_STAT,
        DEV_CTL_ADDR,
        DEV_CTL_DATA,
        DEV_HW_STAT
    } dev_e;

    typedef struct packed {
        logic [ADDR_HI:1] addr;
        logic [AM_W-1:0]  am;
        logic             ds0_n;
        logic             ds1_n;
        logic             lword_n;
        logic             write_n;
    } bus_s;

    typedef struct packed {
        logic       active;
        logic       hit;
        xfer_size_e size;
        dev_e       dev;
    } dec_s;

    function automatic xfer_size_e size_of(input logic ds0_n, input logic ds1_n,
                                           input logic lword_n);
        if (!lword_n)             return SZ_LONG;
        else if (!ds0_n && !ds1_n) return SZ_WORD;
        else if (!ds0_n)           return SZ_ODD;
        else                       return SZ_EVEN;
    endfunction

    function automatic logic size_legal(input xfer_size_e sz);
        return (sz == SZ_WORD) || (sz == SZ_ODD);
    endfunction

    function automatic dev_e dev_of(input logic [IDX_W-1:0] idx, input logic write_n);
        case (idx)
            IDX_CTL_REG:  return write_n ? DEV_CTL_STAT : DEV_CTL_ADDR;
            IDX_CTL_DATA: return DEV_CTL_DATA;
            IDX_HW_STAT:  return DEV_HW_STAT;
            default:      return DEV_NONE;
        endcase
    endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int           W       = 8,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sio_match.sv
module sio_match
    import sio_pkg::*;
(
    input  bus_s       bus,
    input  logic [3:0] base_hi,
    input  logic [3:0] base_mid,
    input  logic [3:0] base_lo,
    input  logic       am2_any,
    output dec_s       dec
);
    logic win_ok;
    logic am_fixed_ok;
    logic am_sw_ok;

    always_comb begin
        win_ok = (bus.addr[15:12] == base_hi) &&
                 (bus.addr[11:8]  == base_mid) &&
                 (bus.addr[7:6]   == base_lo[1:0]);
        // short I/O code family: bits 5,4,3,0 = 1,0,1,1
        am_fixed_ok = bus.am[5] && !bus.am[4] && bus.am[3] && bus.am[0];
        am_sw_ok    = (bus.am[1] == base_lo[2]) &&
                      (am2_any || (bus.am[2] == base_lo[3]));

        dec.active = !bus.ds0_n || !bus.ds1_n;
        dec.hit    = win_ok && am_fixed_ok && am_sw_ok;
        dec.size   = size_of(bus.ds0_n, bus.ds1_n, bus.lword_n);
        dec.dev    = dev_of(bus.addr[5:1], bus.write_n);
    end
endmodule

// File: rtl/sio_cycle.sv
module sio_cycle
    import sio_pkg::*;
#(
    parameter int ACK_DELAY = 2
) (
    input  logic clk,
    input  logic rst,
    input  dec_s dec,
    output dev_e cur_dev,
    output logic dtack,
    output logic berr
);
    localparam int CNT_W = (ACK_DELAY < 2) ? 1 : $clog2(ACK_DELAY);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DELAY - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_ACK, ST_ERR} st_e;

    st_e             state;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cur_dev <= DEV_NONE;
            cnt     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (dec.active && dec.hit) begin
                        if (!size_legal(dec.size)) begin
                            state <= ST_ERR;
                        end else if (dec.dev != DEV_NONE) begin
                            state   <= ST_SEL;
                            cur_dev <= dec.dev;
                            cnt     <= '0;
                        end
                    end
                end
                ST_SEL: begin
                    if (!dec.active) begin
                        state   <= ST_IDLE;
                        cur_dev <= DEV_NONE;
                    end else if (cnt == CNT_LAST) begin
                        state <= ST_ACK;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: begin
                    if (!dec.active) begin
                        state   <= ST_IDLE;
                        cur_dev <= DEV_NONE;
                    end
                end
            endcase
        end
    end

    assign dtack = (state == ST_ACK);
    assign berr  = (state == ST_ERR);

    assert_resp_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(dtack && berr));

    assert_release_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !dec.active |=> !dtack && !berr && (cur_dev == DEV_NONE));

    assert_berr_no_dev_R7: assert property (@(posedge clk) disable iff (rst)
        berr |-> (cur_dev == DEV_NONE));
endmodule

// File: rtl/sio_slave_decoder.sv
module sio_slave_decoder
    import sio_pkg::*;
#(
    parameter int ACK_DELAY   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:1] bus_addr,
    input  logic [5:0]  bus_am,
    input  logic        ds0_n,
    input  logic        ds1_n,
    input  logic        lword_n,
    input  logic        write_n,
    input  logic [3:0]  cfg_base_hi,
    input  logic [3:0]  cfg_base_mid,
    input  logic [3:0]  cfg_base_lo,
    input  logic        cfg_am2_any,
    output logic        sel_ctl_status,
    output logic        sel_ctl_addr,
    output logic        sel_ctl_data,
    output logic        sel_hw_status,
    output logic        dtack,
    output logic        berr
);
    localparam int   BUS_W    = $bits(bus_s);
    localparam bus_s BUS_IDLE = '{addr: '0, am: '0, ds0_n: 1'b1, ds1_n: 1'b1,
                                  lword_n: 1'b1, write_n: 1'b1};

    bus_s raw_bus;
    bus_s sync_bus;
    dec_s dec;
    dev_e cur_dev;

    assign raw_bus = '{addr: bus_addr, am: bus_am, ds0_n: ds0_n, ds1_n: ds1_n,
                       lword_n: lword_n, write_n: write_n};

    sio_sync #(
        .W      (BUS_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(BUS_IDLE)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw_bus),
        .q  (sync_bus)
    );

    sio_match u_match (
        .bus     (sync_bus),
        .base_hi (cfg_base_hi),
        .base_mid(cfg_base_mid),
        .base_lo (cfg_base_lo),
        .am2_any (cfg_am2_any),
        .dec     (dec)
    );

    sio_cycle #(
        .ACK_DELAY(ACK_DELAY)
    ) u_cycle (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .cur_dev(cur_dev),
        .dtack  (dtack),
        .berr   (berr)
    );

    assign sel_ctl_status = (cur_dev == DEV_CTL_STAT);
    assign sel_ctl_addr   = (cur_dev == DEV_CTL_ADDR);
    assign sel_ctl_data   = (cur_dev == DEV_CTL_DATA);
    assign sel_hw_status  = (cur_dev == DEV_HW_STAT);

    assert_ack_one_sel_R8: assert property (@(posedge clk) disable iff (rst)
        dtack |-> ($countones({sel_ctl_status, sel_ctl_addr, sel_ctl_data, sel_hw_status}) == 1));

    assert_sel_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel_ctl_status, sel_ctl_addr, sel_ctl_data, sel_hw_status}));

    assert_ack_after_sel_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(dtack) |-> $past(sel_ctl_status || sel_ctl_addr || sel_ctl_data || sel_hw_status));
endmodule

// File: tb/sim_sio_slave_decoder.sv
module sim_sio_slave_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int ACK_DLY    = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:1] bus_addr = '0;
    logic [5:0]  bus_am = '0;
    logic        ds0_n = 1'b1, ds1_n = 1'b1, lword_n = 1'b1, write_n = 1'b1;
    logic [3:0]  cfg_base_hi = 4'h8, cfg_base_mid = 4'hD, cfg_base_lo = 4'h0;
    logic        cfg_am2_any = 1'b0;
    logic        sel_ctl_status, sel_ctl_addr, sel_ctl_data, sel_hw_status, dtack, berr;
    logic [5:0]  outs;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_slave_decoder #(.ACK_DELAY(ACK_DLY)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_am(bus_am),
        .ds0_n(ds0_n), .ds1_n(ds1_n), .lword_n(lword_n), .write_n(write_n),
        .cfg_base_hi(cfg_base_hi), .cfg_base_mid(cfg_base_mid),
        .cfg_base_lo(cfg_base_lo), .cfg_am2_any(cfg_am2_any),
        .sel_ctl_status(sel_ctl_status), .sel_ctl_addr(sel_ctl_addr),
        .sel_ctl_data(sel_ctl_data), .sel_hw_status(sel_hw_status),
        .dtack(dtack), .berr(berr)
    );

    // {status, addr, data, hw, dtack, berr}
    assign outs = {sel_ctl_status, sel_ctl_addr, sel_ctl_data, sel_hw_status, dtack, berr};

    task automatic check(string req, string what, logic [5:0] act, logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // kind: 0 no response, 1 acknowledged, 2 bus error
    task automatic access(string req, logic [15:0] a, logic [5:0] am, logic d0, logic d1,
                          logic lw, logic wr, logic [3:0] sel, int kind);
        logic [5:0] pend;
        logic [5:0] done;
        pend = (kind == 1) ? {sel, 2'b00} : (kind == 2) ? 6'b000001 : 6'b0;
        done = (kind == 1) ? {sel, 2'b10} : pend;
        @(negedge clk);
        bus_addr = a[15:1]; bus_am = am; ds0_n = d0; ds1_n = d1; lword_n = lw; write_n = wr;
        repeat (3) @(negedge clk);
        check(req, "select edge", outs, pend);
        if (kind == 1) begin
            repeat (ACK_DLY - 1) @(negedge clk);
            check(req, "before ack", outs, pend);
            @(negedge clk);
            check(req, "ack edge", outs, done);
        end else begin
            repeat (ACK_DLY) @(negedge clk);
            check(req, "steady", outs, done);
        end
        repeat (3) @(negedge clk);
        check("R9", "held while strobe low", outs, done);
        ds0_n = 1'b1; ds1_n = 1'b1; lword_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9", "still held after release", outs, done);
        @(negedge clk);
        check("R9", "cleared after release", outs, 6'b0);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_R11();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R11", "during reset", outs, 6'b0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R11", "after reset", outs, 6'b0);
    endtask

    task automatic t_devices_R5_R6();
        cfg_base_hi = 4'h8; cfg_base_mid = 4'hD; cfg_base_lo = 4'h0; cfg_am2_any = 1'b0;
        access("R5", 16'h8D00, 6'h29, 0, 0, 1, 1, 4'b1000, 1);
        access("R5", 16'h8D00, 6'h29, 0, 0, 1, 0, 4'b0100, 1);
        access("R6", 16'h8D02, 6'h29, 0, 0, 1, 0, 4'b0010, 1);
        access("R6", 16'h8D05, 6'h29, 0, 1, 1, 1, 4'b0001, 1);
        access("R8", 16'h8D03, 6'h29, 0, 1, 1, 1, 4'b0010, 1);
    endtask

    task automatic t_window_R1();
        access("R1", 16'h8E00, 6'h29, 0, 0, 1, 1, 4'b0, 0);
        access("R1", 16'h8D40, 6'h29, 0, 0, 1, 1, 4'b0, 0);
        access("R1", 16'h0D00, 6'h29, 0, 0, 1, 1, 4'b0, 0);
        cfg_base_lo = 4'h2;   // A7..A6 = 2'b10, AM code 0x29
        access("R1", 16'h8D80, 6'h29, 0, 0, 1, 1, 4'b1000, 1);
        access("R1", 16'h8D00, 6'h29, 0, 0, 1, 1, 4'b0, 0);
        cfg_base_lo = 4'h0;
    endtask

    task automatic t_am_R2_R3();
        access("R2", 16'h8D00, 6'h39, 0, 0, 1, 1, 4'b0, 0);
        access("R2", 16'h8D00, 6'h28, 0, 0, 1, 1, 4'b0, 0);
        access("R2", 16'h8D00, 6'h09, 0, 0, 1, 1, 4'b0, 0);
        access("R3", 16'h8D00, 6'h2D, 0, 0, 1, 1, 4'b0, 0);
        cfg_base_lo = 4'h8;
        access("R3", 16'h8D00, 6'h2D, 0, 0, 1, 1, 4'b1000, 1);
        access("R3", 16'h8D00, 6'h29, 0, 0, 1, 1, 4'b0, 0);
        cfg_base_lo = 4'h4;
        access("R3", 16'h8D02, 6'h2B, 0, 0, 1, 0, 4'b0010, 1);
        cfg_base_lo = 4'hB;   // A7..A6 = 2'b11, AM code 0x2D
        access("R3", 16'h8DC2, 6'h2D, 0, 0, 1, 1, 4'b0010, 1);
        cfg_base_lo = 4'h0;
    endtask

    task automatic t_am2_any_R4();
        cfg_am2_any = 1'b1;
        access("R4", 16'h8D00, 6'h2D, 0, 0, 1, 1, 4'b1000, 1);
        access("R4", 16'h8D00, 6'h29, 0, 0, 1, 0, 4'b0100, 1);
        access("R4", 16'h8D00, 6'h2B, 0, 0, 1, 1, 4'b0, 0);
        cfg_am2_any = 1'b0;
    endtask

    task automatic t_size_R7();
        access("R7", 16'h8D00, 6'h29, 0, 0, 0, 1, 4'b0, 2);
        access("R7", 16'h8D04, 6'h29, 1, 0, 1, 1, 4'b0, 2);
        access("R7", 16'h8D02, 6'h29, 1, 0, 1, 0, 4'b0, 2);
        access("R7", 16'h8E04, 6'h29, 1, 0, 1, 1, 4'b0, 0);
    endtask

    task automatic t_unmapped_R10();
        access("R10", 16'h8D06, 6'h29, 0, 0, 1, 1, 4'b0, 0);
        access("R10", 16'h8D3E, 6'h29, 0, 0, 1, 0, 4'b0, 0);
        access("R10", 16'h8D21, 6'h29, 0, 1, 1, 1, 4'b0, 0);
    endtask

    initial begin
        t_reset_R11();
        t_devices_R5_R6();
        t_window_R1();
        t_am_R2_R3();
        t_am2_any_R4();
        t_size_R7();
        t_unmapped_R10();
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule